// File: doc/BRIEF.md
# Clock Output-Enable Register Slave on a Two-Wire Serial Bus

This block lets a system controller switch individual differential clock output pairs on and off over a standard-mode (100 kbit/s) two-wire serial bus. It is a write-only bus target that oversamples the serial clock and data lines with a much faster system clock. It answers a single fixed device address and, once addressed, drops two framing bytes. It then loads the data bytes that follow into two 8-bit enable registers, strictly in order.

Each enable bit drives one pair's output-enable. A set bit lets the pair toggle, and a clear bit parks it in high impedance with a low level. The feedback pair has an enable output that is always asserted. Only writes are accepted. A read request or a foreign address goes unacknowledged, and the block then keeps off the bus until the next START.

Top module: `clkout_en_i2c`

## Requirements
- R1: After reset all ten pair enables are 1, and the data line is not pulled low.
- R2: Only the byte D2h (7-bit address 1101001 followed by a 0 write bit, sent MSB first) is acknowledged as an address. Any other first byte, including D3h (read), is not acknowledged. Every later byte of that transfer is also left unacknowledged and changes no enable.
- R3: After the address, the next two bytes (a command byte, then a byte count) are each acknowledged, and their values never reach any enable.
- R4: The first data byte loads register 0. Bit 7 drives pair 0, bit 6 pair 1, and so on down to bit 0, which drives pair 7.
- R5: The second data byte loads register 1. Bit 7 drives pair 8 and bit 6 drives pair 9. Bits 5 to 0 affect no output.
- R6: Data bytes beyond the second are acknowledged and change no enable.
- R7: A STOP or a repeated START ends the transfer. A register that received no complete data byte keeps its value, and a partly shifted byte is dropped. A new START restarts the order at the address byte and register 0.
- R8: The block pulls the data line low only during the acknowledge bit of an accepted byte. It starts on the falling serial clock after the eighth bit and releases on the next falling serial clock.
- R9: The feedback pair enable output is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_low_o | output | 1 | Open-drain pull-down enable for the data line |
| pair_en_o | output | 10 | Output-enable per clock pair, bit n for pair n |
| fb_en_o | output | 1 | Output-enable for the feedback pair |

## Verification
The register load for a data byte and the end of a transfer can meet. A STOP or repeated START can follow the acknowledge of the first data byte, or cut into a half-shifted data byte. In the first case the commit must survive. In the second the partial byte must be dropped, along with the remaining register. The bench provokes both by stopping after one data byte, and by restarting after four bits of a data byte. It judges each case from the enable outputs against a bench-side model of the two registers. A sweep of 64 computed byte pairs and a set of rejected addresses confirms the bit order and the acknowledge pattern.

// File: rtl/oe_pkg.sv
package oe_pkg;

   // receiver control states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_BYTE_END,
      ST_ACK,
      ST_IGNORE
   } rx_state_t;

   // position of the current byte inside one write transfer
   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_CNT,
      PH_DATA
   } rx_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   localparam int NLINES = 2;
   localparam int SCL_IX = 1;
   localparam int SDA_IX = 0;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] synced;
   logic [NLINES-1:0] prev_q;

   assign raw = {scl_i, sda_i};

   for (genvar l = 0; l < NLINES; l++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q <= '1;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], raw[l]};
         end
      end
      assign synced[l] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '1;
      end else begin
         prev_q <= synced;
      end
   end

   assign sda_o      = synced[SDA_IX];
   assign scl_rise_o = synced[SCL_IX] & ~prev_q[SCL_IX];
   assign scl_fall_o = ~synced[SCL_IX] & prev_q[SCL_IX];
   assign start_o    = synced[SCL_IX] & prev_q[SCL_IX] & prev_q[SDA_IX] & ~synced[SDA_IX];
   assign stop_o     = synced[SCL_IX] & prev_q[SCL_IX] & ~prev_q[SDA_IX] & synced[SDA_IX];

endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
   import oe_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         NUM_REGS = 2,
   parameter int         BYTE_W   = 8,
   parameter int         IDX_W    = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sda_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   output logic              sda_low_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [BYTE_W-1:0] wr_data_o
);

   localparam int         CNT_W   = $clog2(BYTE_W);
   localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};

   if (BYTE_W != 8) begin : g_bad_byte
      $error("i2c_wr_rx: BYTE_W must be 8");
   end
   if (NUM_REGS >= (1 << IDX_W)) begin : g_bad_idx
      $error("i2c_wr_rx: IDX_W too narrow for NUM_REGS");
   end

   rx_state_t         st_q;
   rx_phase_t         ph_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [IDX_W-1:0]  data_cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q       <= ST_IDLE;
         ph_q       <= PH_ADDR;
         bit_cnt_q  <= '0;
         shreg_q    <= '0;
         data_cnt_q <= '0;
         sda_low_o  <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_idx_o   <= '0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            st_q       <= ST_RX;
            ph_q       <= PH_ADDR;
            bit_cnt_q  <= '0;
            data_cnt_q <= '0;
            sda_low_o  <= 1'b0;
         end else if (stop_i) begin
            st_q      <= ST_IDLE;
            sda_low_o <= 1'b0;
         end else begin
            unique case (st_q)
               ST_RX: begin
                  if (scl_rise_i) begin
                     shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                     if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
                        st_q <= ST_BYTE_END;
                     end
                  end
               end
               ST_BYTE_END: begin
                  if (scl_fall_i) begin
                     if (ph_q == PH_ADDR && shreg_q != WR_BYTE) begin
                        st_q <= ST_IGNORE;
                     end else begin
                        st_q      <= ST_ACK;
                        sda_low_o <= 1'b1;
                        if (ph_q == PH_DATA && data_cnt_q < IDX_W'(NUM_REGS)) begin
                           wr_en_o    <= 1'b1;
                           wr_idx_o   <= data_cnt_q;
                           wr_data_o  <= shreg_q;
                           data_cnt_q <= data_cnt_q + 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall_i) begin
                     sda_low_o <= 1'b0;
                     st_q      <= ST_RX;
                     if (ph_q != PH_DATA) begin
                        ph_q <= rx_phase_t'(ph_q + 2'd1);
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R8
   ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sda_low_o) |-> $past(scl_fall_i));

   // R8
   ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sda_low_o && scl_fall_i) |=> !sda_low_o);

   // R7
   start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (!sda_low_o && !wr_en_o));

endmodule

// File: rtl/oe_regbank.sv
module oe_regbank #(
   parameter int NUM_PAIRS = 10,
   parameter int REG_W     = 8,
   parameter int NUM_REGS  = 2,
   parameter int IDX_W     = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [IDX_W-1:0]     wr_idx_i,
   input  logic [REG_W-1:0]     wr_data_i,
   output logic [NUM_PAIRS-1:0] pair_en_o
);

   if (NUM_PAIRS > NUM_REGS * REG_W) begin : g_bad_regs
      $error("oe_regbank: not enough register bits for NUM_PAIRS");
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int RI = p / REG_W;
      localparam int BI = REG_W - 1 - (p % REG_W);
      logic en_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q <= 1'b1;
         end else if (wr_en_i && wr_idx_i == IDX_W'(RI)) begin
            en_q <= wr_data_i[BI];
         end
      end
      assign pair_en_o[p] = en_q;

      // R4
      load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_en_i && wr_idx_i == IDX_W'(RI)) |=> pair_en_o[p] == $past(wr_data_i[BI]));

      // R7
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wr_en_i |=> $stable(pair_en_o[p]));
   end

endmodule

// File: rtl/clkout_en_i2c.sv
module clkout_en_i2c #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_PAIRS   = 10,
   parameter int         REG_W       = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_low_o,
   output logic [NUM_PAIRS-1:0] pair_en_o,
   output logic                 fb_en_o
);

   localparam int NUM_REGS = (NUM_PAIRS + REG_W - 1) / REG_W;
   localparam int IDX_W    = $clog2(NUM_REGS + 1);

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("clkout_en_i2c: NUM_PAIRS must be positive");
   end

   logic             sda_s;
   logic             start_p;
   logic             stop_p;
   logic             scl_rise;
   logic             scl_fall;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [REG_W-1:0] wr_data;

   i2c_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .start_o    (start_p),
      .stop_o     (stop_p),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   i2c_wr_rx #(
      .DEV_ADDR (DEV_ADDR),
      .NUM_REGS (NUM_REGS),
      .BYTE_W   (REG_W),
      .IDX_W    (IDX_W)
   ) u_rx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sda_i      (sda_s),
      .start_i    (start_p),
      .stop_i     (stop_p),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .sda_low_o  (sda_low_o),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx),
      .wr_data_o  (wr_data)
   );

   oe_regbank #(
      .NUM_PAIRS (NUM_PAIRS),
      .REG_W     (REG_W),
      .NUM_REGS  (NUM_REGS),
      .IDX_W     (IDX_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .pair_en_o (pair_en_o)
   );

   assign fb_en_o = 1'b1;

   // R7
   wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

endmodule

// File: tb/clkout_en_i2c_tb_top.sv
module clkout_en_i2c_tb_top;

   localparam int Q = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_line;
   logic       sda_low;
   logic [9:0] pair_en;
   logic       fb_en;

   int n_chk = 0;
   int n_fail = 0;
   int spur = 0;
   logic [7:0] mr0 = 8'hFF;
   logic [7:0] mr1 = 8'hFF;

   always #10 clk = ~clk;

   assign sda_line = m_sda & ~sda_low;

   clkout_en_i2c dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_low_o (sda_low),
      .pair_en_o (pair_en),
      .fb_en_o   (fb_en)
   );

   function automatic logic [9:0] exp_map(input logic [7:0] r0, input logic [7:0] r1);
      logic [9:0] m;
      for (int p = 0; p < 8; p++) m[p] = r0[7-p];
      m[8] = r1[7];
      m[9] = r1[6];
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic rep_start();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int nbits, output bit acked);
      for (int i = 7; i > 7 - nbits; i--) begin
         m_sda = b[i]; wq(Q);
         m_scl = 1'b1; wq(Q);
         if (b[i] && !sda_line) spur++;
         wq(Q);
         m_scl = 1'b0; wq(Q);
      end
      acked = 1'b0;
      if (nbits == 8) begin
         m_sda = 1'b1; wq(Q);
         m_scl = 1'b1; wq(Q);
         acked = !sda_line;
         wq(Q);
         m_scl = 1'b0; wq(Q);
      end
   endtask

   // sends addr, cmd, cnt and ndata bytes from dw (MSB byte first); returns ack mask
   task automatic txn(input bit rep, input logic [7:0] addr, input logic [7:0] cmd,
                      input logic [7:0] cnt, input logic [31:0] dw, input int ndata,
                      input bit do_stop, output logic [6:0] acks);
      bit a;
      acks = '0;
      if (rep) rep_start(); else bus_start();
      send_byte(addr, 8, a); acks[0] = a;
      send_byte(cmd, 8, a);  acks[1] = a;
      send_byte(cnt, 8, a);  acks[2] = a;
      for (int k = 0; k < ndata; k++) begin
         send_byte(dw[31-8*k -: 8], 8, a);
         acks[3+k] = a;
      end
      if (do_stop) bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [6:0] acks;
      logic [7:0] b0, b1;
      logic [7:0] bad [6];
      bit a;
      bad = '{8'hD3, 8'hD0, 8'h52, 8'h00, 8'hFF, 8'hD6};

      wq(5);
      rst_n = 1'b1;
      wq(5);
      // R1 reset state
      chk(pair_en == 10'h3FF, "R1 reset enables", 16'(pair_en), 16'h3FF);
      chk(sda_low == 1'b0, "R1 reset data line", 16'(sda_low), 16'h0);
      chk(fb_en == 1'b1, "R9 feedback enable", 16'(fb_en), 16'h1);

      // R4 R5 sweep of computed byte pairs
      for (int i = 0; i < 64; i++) begin
         b0 = 8'((i * 37 + 5) % 256);
         b1 = 8'((i * 91 + 3) % 256);
         txn(1'b0, 8'hD2, 8'h00, 8'h02, {b0, b1, 16'h0}, 2, 1'b1, acks);
         mr0 = b0; mr1 = b1;
         chk(acks[4:0] == 5'h1F, "R2 R3 ack pattern", 16'(acks), 16'h1F);
         chk(pair_en == exp_map(mr0, mr1), "R4 R5 sweep enables", 16'(pair_en), 16'(exp_map(mr0, mr1)));
         chk(fb_en == 1'b1, "R9 feedback enable", 16'(fb_en), 16'h1);
      end

      // R5 reserved bits of register 1 have no effect
      txn(1'b0, 8'hD2, 8'h00, 8'h02, {8'h5A, 8'h80, 16'h0}, 2, 1'b1, acks);
      txn(1'b0, 8'hD2, 8'h00, 8'h02, {8'h5A, 8'hBF, 16'h0}, 2, 1'b1, acks);
      mr0 = 8'h5A; mr1 = 8'hBF;
      chk(pair_en == exp_map(mr0, mr1), "R5 reserved bits", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R2 foreign addresses and read requests
      for (int i = 0; i < 6; i++) begin
         txn(1'b0, bad[i], 8'h00, 8'h02, {8'h00, 8'h00, 16'h0}, 2, 1'b1, acks);
         chk(acks == 7'h00, "R2 no ack on wrong address", 16'(acks), 16'h0);
         chk(pair_en == exp_map(mr0, mr1), "R2 enables unchanged", 16'(pair_en), 16'(exp_map(mr0, mr1)));
      end

      // R3 command and count bytes only
      txn(1'b0, 8'hD2, 8'h00, 8'h00, 32'h0, 0, 1'b1, acks);
      chk(acks[2:0] == 3'h7, "R3 ack cmd and count", 16'(acks), 16'h7);
      chk(pair_en == exp_map(mr0, mr1), "R3 values ignored", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R7 one data byte then STOP keeps register 1
      txn(1'b0, 8'hD2, 8'h11, 8'h01, {8'h0F, 24'h0}, 1, 1'b1, acks);
      mr0 = 8'h0F;
      chk(pair_en == exp_map(mr0, mr1), "R7 stop after one byte", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R6 extra data bytes acknowledged and discarded
      txn(1'b0, 8'hD2, 8'hAA, 8'h04, {8'hC3, 8'h40, 8'h00, 8'h00}, 4, 1'b1, acks);
      mr0 = 8'hC3; mr1 = 8'h40;
      chk(acks == 7'h7F, "R6 extra bytes acked", 16'(acks), 16'h7F);
      chk(pair_en == exp_map(mr0, mr1), "R6 extra bytes ignored", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R7 repeated START after one data byte, new transfer restarts at register 0
      txn(1'b0, 8'hD2, 8'h00, 8'h02, {8'h99, 24'h0}, 1, 1'b0, acks);
      mr0 = 8'h99;
      chk(pair_en == exp_map(mr0, mr1), "R7 commit before restart", 16'(pair_en), 16'(exp_map(mr0, mr1)));
      txn(1'b1, 8'hD2, 8'h00, 8'h02, {8'h66, 8'hC0, 16'h0}, 2, 1'b1, acks);
      mr0 = 8'h66; mr1 = 8'hC0;
      chk(pair_en == exp_map(mr0, mr1), "R7 restart order", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R7 partial data byte cut by repeated START then STOP
      bus_start();
      send_byte(8'hD2, 8, a);
      send_byte(8'h00, 8, a);
      send_byte(8'h02, 8, a);
      send_byte(8'h00, 4, a);
      rep_start();
      bus_stop();
      chk(pair_en == exp_map(mr0, mr1), "R7 partial byte dropped", 16'(pair_en), 16'(exp_map(mr0, mr1)));

      // R8 data line only pulled during acknowledge bits
      chk(spur == 0, "R8 no pull outside ack", 16'(spur), 16'h0);
      chk(sda_low == 1'b0, "R8 released when idle", 16'(sda_low), 16'h0);
      chk(fb_en == 1'b1, "R9 feedback enable", 16'(fb_en), 16'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule